// File: doc/BRIEF.md
# Brown-out detector mode controller

This controller sequences an external supply-voltage comparator and turns its verdict into a clean reset request for the system. Two 2-bit mode settings exist. One governs the awake states (running and idle). The other governs every deeper sleep state. A single sleep flag picks which setting is in force. The selected code turns the detector off, keeps it on continuously, or powers it in short bursts paced by a slow 1 kHz low-power tick.

In burst (sampled) mode the detector stays unpowered between ticks. On each rising edge of the tick it is powered for one settling cycle, and then a one-cycle sample strobe is given. If the comparator reports a low supply during the strobe, the controller escalates: it keeps the detector on continuously and holds the reset request until the supply is back above threshold. While escalated it ignores the mode settings and the sleep flag. After recovery it returns to whatever mode the current sleep state selects.

States: OFF (detector unpowered), CONT (continuous monitoring), SMP_WAIT (sampled, waiting for a tick edge), SMP_SETTLE (detector powered, settling), SMP_STROBE (sample taken) and FAULT (reset held, detector on). Transitions: any non-FAULT state to its home state (OFF, CONT or SMP_WAIT) when the selected mode differs from the one it belongs to; SMP_WAIT to SMP_SETTLE on a tick rising edge; SMP_SETTLE to SMP_STROBE after the settle count; SMP_STROBE to FAULT on a low supply, otherwise back to SMP_WAIT; CONT to FAULT on a low supply; FAULT to the home state once the supply is good.

Top module: `bod_mode_ctrl`

## Requirements
- R1: Mode codes 2'b10 (off) and 2'b00 (reserved, treated as off) keep det_en, smp_stb and bor_req low, even while cmp_low is high.
- R2: Mode code 2'b11 raises det_en one clock edge after it is selected, with smp_stb staying low.
- R3: With asleep low the controller follows mode_awake, and with asleep high it follows mode_sleep. A change takes effect at the next clock edge.
- R4: In mode code 2'b01, det_en is low between samples. For a tick rising edge seen at clock edge E, det_en is high from E, smp_stb is high for exactly the cycle after E+1, and det_en falls at E+2 when the supply is good.
- R5: Each tick rising edge gives exactly one sample. A tick held high gives no further samples, and a cmp_low pulse outside the strobe cycle has no effect.
- R6: A cmp_low seen during the strobe makes bor_req and det_en high from the next edge. Both stay high for as long as cmp_low stays high.
- R7: In mode code 2'b11, cmp_low raises bor_req at the next edge. bor_req falls at the first edge at which cmp_low is seen low.
- R8: While bor_req is high, changes of the mode settings or of asleep neither release bor_req nor lower det_en.
- R9: After recovery the controller enters the mode selected by the current asleep and mode inputs.
- R10: During reset and immediately after it, all three outputs are low.
- R11: bor_req is a registered output and is never high while det_en is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_awake | input | 2 | Mode code used while awake or idle |
| mode_sleep | input | 2 | Mode code used in deeper sleep |
| asleep | input | 1 | High selects mode_sleep |
| lp_tick | input | 1 | 1 kHz low-power tick |
| cmp_low | input | 1 | Comparator: supply below threshold |
| det_en | output | 1 | Detector power enable |
| smp_stb | output | 1 | Sample strobe |
| bor_req | output | 1 | Brown-out reset request |

## Verification
Every output is a flop loaded from the next-state decode, so a change of mode, sleep flag or comparator level shows at the ports one edge later. A tick rising edge seen at edge E gives det_en after E and the strobe after E+1, and the fault verdict appears after E+2. The bench drives inputs on the falling edge, then samples after the next rising edge at the following falling edge. Directed checks count edges from the stimulus to the exact cycle listed here. A cycle-level reference model is stepped at every rising edge and is compared each cycle during a long random run.

// File: rtl/bod_pkg.sv
package bod_pkg;

    typedef enum logic [1:0] {
        CODE_RSVD    = 2'b00,
        CODE_SAMPLED = 2'b01,
        CODE_OFF     = 2'b10,
        CODE_CONT    = 2'b11
    } bod_code_t;

    typedef enum logic [1:0] {
        SEL_OFF,
        SEL_CONT,
        SEL_SAMPLED
    } bod_sel_t;

    typedef enum logic [2:0] {
        ST_OFF,
        ST_CONT,
        ST_SMP_WAIT,
        ST_SMP_SETTLE,
        ST_SMP_STROBE,
        ST_FAULT
    } bod_state_t;

endpackage

// File: rtl/bod_mode_sel.sv
module bod_mode_sel
    import bod_pkg::*;
#(
    parameter int CODE_W = 2
) (
    input  logic [CODE_W-1:0] mode_awake,
    input  logic [CODE_W-1:0] mode_sleep,
    input  logic              asleep,
    output bod_sel_t          sel
);

    logic [CODE_W-1:0] code;

    assign code = asleep ? mode_sleep : mode_awake;

    always_comb begin
        unique case (code[1:0])
            CODE_SAMPLED: sel = SEL_SAMPLED;
            CODE_CONT:    sel = SEL_CONT;
            default:      sel = SEL_OFF;
        endcase
    end

endmodule

// File: rtl/bod_tick_edge.sv
module bod_tick_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    output logic rise
);

    logic tick_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tick_q <= 1'b0;
        else        tick_q <= tick;
    end

    assign rise = tick & ~tick_q;

endmodule

// File: rtl/bod_seq_fsm.sv
module bod_seq_fsm
    import bod_pkg::*;
#(
    parameter int SETTLE_CYC = 1
) (
    input  logic     clk,
    input  logic     rst_n,
    input  bod_sel_t sel,
    input  logic     tick_rise,
    input  logic     cmp_low,
    output logic     det_en,
    output logic     smp_stb,
    output logic     bor_req
);

    localparam int CW = (SETTLE_CYC > 1) ? $clog2(SETTLE_CYC) : 1;
    localparam logic [CW-1:0] CNT_LAST = CW'(SETTLE_CYC - 1);

    bod_state_t state, nxt, home;
    logic [CW-1:0] cnt, cnt_nxt;

    always_comb begin
        unique case (sel)
            SEL_CONT:    home = ST_CONT;
            SEL_SAMPLED: home = ST_SMP_WAIT;
            default:     home = ST_OFF;
        endcase
    end

    always_comb begin
        nxt     = state;
        cnt_nxt = cnt;
        unique case (state)
            ST_FAULT: begin
                if (!cmp_low) nxt = home;
            end
            ST_OFF: begin
                nxt = home;
            end
            ST_CONT: begin
                if (sel == SEL_CONT && cmp_low) nxt = ST_FAULT;
                else                            nxt = home;
            end
            ST_SMP_WAIT: begin
                if (sel != SEL_SAMPLED) nxt = home;
                else if (tick_rise) begin
                    nxt     = ST_SMP_SETTLE;
                    cnt_nxt = '0;
                end
            end
            ST_SMP_SETTLE: begin
                if (sel != SEL_SAMPLED)  nxt = home;
                else if (cnt == CNT_LAST) nxt = ST_SMP_STROBE;
                else                     cnt_nxt = cnt + 1'b1;
            end
            ST_SMP_STROBE: begin
                if (sel != SEL_SAMPLED) nxt = home;
                else if (cmp_low)       nxt = ST_FAULT;
                else                    nxt = ST_SMP_WAIT;
            end
            default: nxt = ST_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_OFF;
            cnt   <= '0;
        end else begin
            state <= nxt;
            cnt   <= cnt_nxt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            det_en  <= 1'b0;
            smp_stb <= 1'b0;
            bor_req <= 1'b0;
        end else begin
            det_en  <= (nxt == ST_CONT) || (nxt == ST_SMP_SETTLE) ||
                       (nxt == ST_SMP_STROBE) || (nxt == ST_FAULT);
            smp_stb <= (nxt == ST_SMP_STROBE);
            bor_req <= (nxt == ST_FAULT);
        end
    end

endmodule

// File: rtl/bod_mode_ctrl.sv
module bod_mode_ctrl
    import bod_pkg::*;
#(
    parameter int CODE_W     = 2,
    parameter int SETTLE_CYC = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] mode_awake,
    input  logic [CODE_W-1:0] mode_sleep,
    input  logic              asleep,
    input  logic              lp_tick,
    input  logic              cmp_low,
    output logic              det_en,
    output logic              smp_stb,
    output logic              bor_req
);

    bod_sel_t sel;
    logic     tick_rise;

    bod_mode_sel #(.CODE_W(CODE_W)) u_sel (
        .mode_awake (mode_awake),
        .mode_sleep (mode_sleep),
        .asleep     (asleep),
        .sel        (sel)
    );

    bod_tick_edge u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (lp_tick),
        .rise  (tick_rise)
    );

    bod_seq_fsm #(.SETTLE_CYC(SETTLE_CYC)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel       (sel),
        .tick_rise (tick_rise),
        .cmp_low   (cmp_low),
        .det_en    (det_en),
        .smp_stb   (smp_stb),
        .bor_req   (bor_req)
    );

endmodule

// File: rtl/bod_mode_ctrl_chk.sv
module bod_mode_ctrl_chk #(
    parameter int CODE_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [CODE_W-1:0] mode_awake,
    input logic [CODE_W-1:0] mode_sleep,
    input logic              asleep,
    input logic              cmp_low,
    input logic              det_en,
    input logic              smp_stb,
    input logic              bor_req
);

    logic [1:0] eff;
    assign eff = asleep ? mode_sleep[1:0] : mode_awake[1:0];

    // R1
    off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!bor_req && !eff[0]) |=> (!det_en && !smp_stb && !bor_req));

    // R2
    cont_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!bor_req && eff == 2'b11 && !cmp_low) |=> (det_en && !smp_stb && !bor_req));

    // R4
    settle_before_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        smp_stb |-> $past(det_en));

    // R4
    strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        smp_stb |=> !smp_stb);

    // R6
    sample_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_stb && cmp_low && eff == 2'b01) |=> (bor_req && det_en));

    // R8
    fault_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bor_req && cmp_low) |=> bor_req);

    // R7
    fault_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bor_req && !cmp_low) |=> !bor_req);

    // R11
    req_needs_det_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bor_req |-> det_en);

endmodule

bind bod_mode_ctrl bod_mode_ctrl_chk #(.CODE_W(CODE_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_awake (mode_awake),
    .mode_sleep (mode_sleep),
    .asleep     (asleep),
    .cmp_low    (cmp_low),
    .det_en     (det_en),
    .smp_stb    (smp_stb),
    .bor_req    (bor_req)
);

// File: tb/bod_mode_ctrl_test.sv
module bod_mode_ctrl_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] mode_awake = 2'b10;
    logic [1:0] mode_sleep = 2'b10;
    logic       asleep = 1'b0;
    logic       lp_tick = 1'b0;
    logic       cmp_low = 1'b0;
    logic       det_en, smp_stb, bor_req;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // reference model: 0 off, 1 cont, 2 wait, 3 settle, 4 strobe, 5 fault
    int  m_st = 0;
    bit  m_tq = 1'b0;

    always #4 clk = ~clk;

    bod_mode_ctrl uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_awake (mode_awake),
        .mode_sleep (mode_sleep),
        .asleep     (asleep),
        .lp_tick    (lp_tick),
        .cmp_low    (cmp_low),
        .det_en     (det_en),
        .smp_stb    (smp_stb),
        .bor_req    (bor_req)
    );

    function automatic int home_of(input logic [1:0] code);
        if (code == 2'b01) return 2;
        if (code == 2'b11) return 1;
        return 0;
    endfunction

    function automatic bit exp_det(input int s);
        return (s == 1) || (s == 3) || (s == 4) || (s == 5);
    endfunction

    task automatic model_update();
        logic [1:0] code;
        bit rise;
        int h;
        code = asleep ? mode_sleep : mode_awake;
        rise = lp_tick && !m_tq;
        m_tq = lp_tick;
        h = home_of(code);
        case (m_st)
            5: if (!cmp_low) m_st = h;
            0: m_st = h;
            1: m_st = (h == 1 && cmp_low) ? 5 : h;
            2: if (h != 2) m_st = h; else if (rise) m_st = 3;
            3: m_st = (h != 2) ? h : 4;
            4: m_st = (h != 2) ? h : (cmp_low ? 5 : 2);
            default: m_st = 0;
        endcase
    endtask

    task automatic step();
        @(posedge clk);
        if (rst_n) model_update();
        @(negedge clk);
    endtask

    task automatic steps(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic check(input string tag, input logic got, input logic exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %b expected %b", tag, got, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        bit stb_seen;
        bit bad_any;
        repeat (3) @(negedge clk);
        // R10 outputs during reset
        check("R10 det_en in reset", det_en, 1'b0);
        check("R10 bor_req in reset", bor_req, 1'b0);
        rst_n = 1'b1;
        step();
        check("R10 det_en after reset", det_en, 1'b0);
        check("R10 smp_stb after reset", smp_stb, 1'b0);
        check("R10 bor_req after reset", bor_req, 1'b0);

        // R1 off and reserved codes ignore the comparator
        cmp_low = 1'b1;
        mode_awake = 2'b10;
        steps(4);
        check("R1 off det_en", det_en, 1'b0);
        check("R1 off bor_req", bor_req, 1'b0);
        mode_awake = 2'b00;
        steps(4);
        check("R1 reserved det_en", det_en, 1'b0);
        check("R1 reserved bor_req", bor_req, 1'b0);
        check("R1 reserved smp_stb", smp_stb, 1'b0);

        // R2 continuous mode
        cmp_low = 1'b0;
        mode_awake = 2'b11;
        step();
        check("R2 det_en after one edge", det_en, 1'b1);
        check("R2 no strobe", smp_stb, 1'b0);

        // R7 continuous fault and release
        cmp_low = 1'b1;
        step();
        check("R7 bor_req raised", bor_req, 1'b1);
        steps(3);
        check("R7 bor_req held", bor_req, 1'b1);
        cmp_low = 1'b0;
        step();
        check("R7 bor_req released", bor_req, 1'b0);
        check("R7 det_en still on", det_en, 1'b1);

        // R3 sleep selection
        mode_sleep = 2'b10;
        asleep = 1'b1;
        step();
        check("R3 sleep setting off", det_en, 1'b0);
        asleep = 1'b0;
        step();
        check("R3 awake setting cont", det_en, 1'b1);

        // R4 sampled sequence
        mode_awake = 2'b01;
        steps(3);
        check("R4 idle between samples", det_en, 1'b0);
        lp_tick = 1'b1;
        step();
        check("R4 det_en at E", det_en, 1'b1);
        check("R4 no strobe at E", smp_stb, 1'b0);
        step();
        check("R4 strobe at E+1", smp_stb, 1'b1);
        check("R4 det_en at E+1", det_en, 1'b1);
        step();
        check("R4 strobe gone at E+2", smp_stb, 1'b0);
        check("R4 det_en off at E+2", det_en, 1'b0);
        check("R4 no fault", bor_req, 1'b0);

        // R5 tick held high, glitch between samples ignored
        stb_seen = 1'b0;
        for (int i = 0; i < 10; i++) begin
            cmp_low = (i == 4);
            step();
            if (smp_stb || bor_req) stb_seen = 1'b1;
        end
        check("R5 no extra sample or fault", stb_seen, 1'b0);

        // R6 fault at sample
        lp_tick = 1'b0;
        steps(2);
        cmp_low = 1'b1;
        lp_tick = 1'b1;
        steps(2);
        check("R6 no reset before sample", bor_req, 1'b0);
        step();
        check("R6 bor_req after sample", bor_req, 1'b1);
        check("R6 det_en escalated", det_en, 1'b1);
        steps(5);
        check("R6 held while low", bor_req, 1'b1);

        // R8 settings ignored while escalated
        mode_sleep = 2'b10;
        asleep = 1'b1;
        mode_awake = 2'b00;
        steps(3);
        check("R8 bor_req held", bor_req, 1'b1);
        check("R8 det_en held", det_en, 1'b1);

        // R9 return to current selection
        cmp_low = 1'b0;
        step();
        check("R9 bor_req released", bor_req, 1'b0);
        check("R9 back to sleep setting off", det_en, 1'b0);

        // random phase compared against the model
        void'($urandom(32'h5eed_b0d5));
        bad_any = 1'b0;
        for (int i = 0; i < 4000; i++) begin
            if ($urandom_range(31) == 0) mode_awake = 2'($urandom_range(3));
            if ($urandom_range(31) == 0) mode_sleep = 2'($urandom_range(3));
            if ($urandom_range(15) == 0) asleep = ~asleep;
            if ($urandom_range(7) == 0)  lp_tick = ~lp_tick;
            cmp_low = ($urandom_range(5) == 0);
            step();
            if (det_en !== exp_det(m_st) || smp_stb !== (m_st == 4) ||
                bor_req !== (m_st == 5)) begin
                if (!bad_any)
                    $display("FAIL R3/R11 random cycle %0d: got %b%b%b expected %b%b%b",
                             i, det_en, smp_stb, bor_req,
                             exp_det(m_st), m_st == 4, m_st == 5);
                bad_any = 1'b1;
            end
            if (bor_req && !det_en) bad_any = 1'b1;
        end
        n_chk++;
        if (bad_any) n_bad++;

        finish_run();
    end

endmodule